// File: doc/BRIEF.md
# Toggle-Acknowledged Global Error Interrupt Controller

This block keeps the global error state of a larger engine in two registers of equal width: an error-status register that only hardware changes and an acknowledge register that only software writes. An error bit is active while the two copies of that bit hold different values. Hardware raises errors by presenting a bit mask, and the block flips only those status bits that are not active already. Software retires errors by writing the acknowledge register so that the chosen bits match the status bits again. No bit is ever set or cleared by an acknowledge; every change is a toggle.

Three wired interrupt outputs carry single-cycle pulses: global error, event queue and command-sync completion. Each has its own gating rule. The global-error line is gated by an enable bit and fires on every report that flips at least one fresh bit. The event-queue line is gated by a second enable bit. The command-sync line has no gate. A request for an interrupt type that is not implemented raises no line and produces a one-cycle unimplemented flag. Software reaches the registers through a plain port with a write strobe, a 2-bit address and a combinational read path.

Top module: `gerr_irq_ctrl`

## Requirements
- R1: Register map on `reg_addr`: 0 error status, 1 acknowledge, 2 interrupt control, 3 reads as zero. Interrupt control keeps only bit 0 (global-error enable) and bit 2 (event-queue enable); all other bits read 0. After reset all three registers read 0. A bit is active when its status and acknowledge bits differ.
- R2: A hardware report (`err_rep_valid` with `err_rep_mask`) toggles exactly the mask bits that are not active; active bits are left unchanged.
- R3: A report whose mask holds no inactive bits changes no register and raises no interrupt.
- R4: `irq_gerr` pulses after a report that toggled at least one bit while the global-error enable (control bit 0) is 1, also when older errors are still unacknowledged; it stays low when the enable is 0.
- R5: Every interrupt output and `unimpl_flag` is high for exactly one cycle, the cycle after the edge that samples the cause.
- R6: `irq_evq` pulses after `evq_req` only when the event-queue enable (control bit 2) is 1.
- R7: `irq_sync` pulses after every `sync_req`, whatever the control register holds.
- R8: A write to the acknowledge register stores the written value unmasked; the active set follows from the new value.
- R9: Toggling an acknowledge bit of an inactive error raises no interrupt; the value is kept as written.
- R10: `priq_req` raises none of the three interrupt lines and pulses `unimpl_flag`.
- R11: When an acknowledge write and a report arrive in the same cycle, the report is tested against the active set that results from the write.
- R12: Writes to address 0 do not change the error-status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_rep_valid | input | 1 | Hardware error report strobe |
| err_rep_mask | input | NERR | Error bits being reported |
| evq_req | input | 1 | Event-queue interrupt request |
| sync_req | input | 1 | Command-sync completion request |
| priq_req | input | 1 | Request on an unimplemented interrupt type |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| irq_gerr | output | 1 | Global error interrupt pulse |
| irq_evq | output | 1 | Event-queue interrupt pulse |
| irq_sync | output | 1 | Command-sync completion interrupt pulse |
| unimpl_flag | output | 1 | Pulse marking an unimplemented interrupt request |

## Verification
Error reports are tried on an idle register pair, with masks that partly overlap errors still outstanding, and with masks made only of outstanding bits; these separate a correct fresh-bit filter from one that toggles everything or drops the whole report, and separate a pulse-on-any-fresh rule from one that waits for all errors to be cleared. Acknowledge writes cover retiring active bits and flipping an inactive bit, which distinguishes verbatim storage from masking. A collision of an acknowledge write and a report tells the write-first order from report-first. The request lines run with each enable set and cleared to tell apart the gated, ungated and unimplemented paths.

// File: rtl/gerr_pkg.sv
package gerr_pkg;
  localparam int unsigned AW            = 2;
  localparam int unsigned CTRL_GERR_BIT = 0;
  localparam int unsigned CTRL_EVQ_BIT  = 2;

  typedef enum logic [AW-1:0] {
    RA_STATUS = 2'd0,
    RA_ACK    = 2'd1,
    RA_CTRL   = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;

  typedef enum int unsigned {
    LN_GERR = 0,
    LN_EVQ  = 1,
    LN_SYNC = 2,
    LN_UNIM = 3
  } line_e;

  localparam int unsigned NLINES = 4;
endpackage

// File: rtl/gerr_err_state.sv
module gerr_err_state #(
  parameter int unsigned NERR = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_we,
  input  logic [NERR-1:0] ack_wdata,
  input  logic            rep_valid,
  input  logic [NERR-1:0] rep_mask,
  output logic [NERR-1:0] status_q,
  output logic [NERR-1:0] ack_q,
  output logic [NERR-1:0] fresh_o,
  output logic            fresh_any_o
);
  // Active set seen by a report: taken after this cycle's acknowledge write.
  function automatic logic [NERR-1:0] active_of(input logic [NERR-1:0] st,
                                                input logic [NERR-1:0] ak);
    return st ^ ak;
  endfunction

  function automatic logic [NERR-1:0] fresh_of(input logic [NERR-1:0] mask,
                                               input logic [NERR-1:0] act);
    return mask & ~act;
  endfunction

  logic [NERR-1:0] ack_next;
  logic [NERR-1:0] active_after_ack;

  always_comb begin
    ack_next         = ack_we ? ack_wdata : ack_q;
    active_after_ack = active_of(status_q, ack_next);
    fresh_o          = rep_valid ? fresh_of(rep_mask, active_after_ack) : '0;
    fresh_any_o      = |fresh_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ack_q    <= '0;
    end else begin
      status_q <= status_q ^ fresh_o;
      ack_q    <= ack_next;
    end
  end

  AST_ACTIVE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q ^ $past(status_q)) & $past(active_after_ack)) == '0); // R2
  AST_STALE_REPORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !fresh_any_o) |=> $stable(status_q)); // R3
  AST_ACK_VERBATIM: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> (ack_q == $past(ack_wdata))); // R8
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_we |=> $stable(ack_q)); // R8
endmodule

// File: rtl/gerr_irq_pulse.sv
module gerr_irq_pulse
  import gerr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fresh_any,
  input  logic en_gerr,
  input  logic en_evq,
  input  logic evq_req,
  input  logic sync_req,
  input  logic priq_req,
  output logic irq_gerr,
  output logic irq_evq,
  output logic irq_sync,
  output logic unimpl_flag
);
  logic [NLINES-1:0] cause;
  logic [NLINES-1:0] line_q;

  always_comb begin
    cause          = '0;
    cause[LN_GERR] = fresh_any & en_gerr;
    cause[LN_EVQ]  = evq_req & en_evq;
    cause[LN_SYNC] = sync_req;
    cause[LN_UNIM] = priq_req;
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q[g] <= 1'b0;
      else        line_q[g] <= cause[g];
    end
  end

  assign irq_gerr    = line_q[LN_GERR];
  assign irq_evq     = line_q[LN_EVQ];
  assign irq_sync    = line_q[LN_SYNC];
  assign unimpl_flag = line_q[LN_UNIM];

  AST_GERR_ON_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh_any && en_gerr) |=> irq_gerr); // R4
  AST_GERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(fresh_any && en_gerr) |=> !irq_gerr); // R3
  AST_EVQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_evq |=> !irq_evq); // R6
  AST_SYNC_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> irq_sync); // R7
  AST_PRIQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    priq_req |=> unimpl_flag); // R10
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_req |=> !irq_sync); // R5
endmodule

// File: rtl/gerr_regs.sv
module gerr_regs
  import gerr_pkg::*;
#(
  parameter int unsigned NERR = 8,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic [NERR-1:0] status,
  input  logic [NERR-1:0] ack,
  output logic            ack_we,
  output logic [NERR-1:0] ack_wdata,
  output logic            en_gerr,
  output logic            en_evq,
  output logic [DW-1:0]   reg_rdata
);
  localparam logic [DW-1:0] CTRL_MASK = (DW'(1) << CTRL_GERR_BIT) | (DW'(1) << CTRL_EVQ_BIT);

  reg_addr_e addr;
  logic      ctrl_we;

  assign addr      = reg_addr_e'(reg_addr);
  assign ack_we    = reg_we && (addr == RA_ACK);
  assign ctrl_we   = reg_we && (addr == RA_CTRL);
  assign ack_wdata = reg_wdata[NERR-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_gerr <= 1'b0;
      en_evq  <= 1'b0;
    end else if (ctrl_we) begin
      en_gerr <= reg_wdata[CTRL_GERR_BIT];
      en_evq  <= reg_wdata[CTRL_EVQ_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (addr)
      RA_STATUS: reg_rdata = DW'(status);
      RA_ACK:    reg_rdata = DW'(ack);
      RA_CTRL: begin
        reg_rdata[CTRL_GERR_BIT] = en_gerr;
        reg_rdata[CTRL_EVQ_BIT]  = en_evq;
      end
      default:   reg_rdata = '0;
    endcase
  end

  AST_CTRL_SPARSE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == RA_CTRL) |-> ((reg_rdata & ~CTRL_MASK) == '0)); // R1
  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> ($stable(en_gerr) && $stable(en_evq))); // R1
endmodule

// File: rtl/gerr_irq_ctrl.sv
module gerr_irq_ctrl
  import gerr_pkg::*;
#(
  parameter int unsigned NERR = 8,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            err_rep_valid,
  input  logic [NERR-1:0] err_rep_mask,
  input  logic            evq_req,
  input  logic            sync_req,
  input  logic            priq_req,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_gerr,
  output logic            irq_evq,
  output logic            irq_sync,
  output logic            unimpl_flag
);
  logic [NERR-1:0] status_q;
  logic [NERR-1:0] ack_q;
  logic [NERR-1:0] fresh;
  logic            fresh_any;
  logic            ack_we;
  logic [NERR-1:0] ack_wdata;
  logic            en_gerr;
  logic            en_evq;

  gerr_regs #(.NERR(NERR), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status(status_q), .ack(ack_q),
    .ack_we(ack_we), .ack_wdata(ack_wdata),
    .en_gerr(en_gerr), .en_evq(en_evq),
    .reg_rdata(reg_rdata)
  );

  gerr_err_state #(.NERR(NERR)) state_i (
    .clk(clk), .rst_n(rst_n),
    .ack_we(ack_we), .ack_wdata(ack_wdata),
    .rep_valid(err_rep_valid), .rep_mask(err_rep_mask),
    .status_q(status_q), .ack_q(ack_q),
    .fresh_o(fresh), .fresh_any_o(fresh_any)
  );

  gerr_irq_pulse pulse_i (
    .clk(clk), .rst_n(rst_n),
    .fresh_any(fresh_any), .en_gerr(en_gerr), .en_evq(en_evq),
    .evq_req(evq_req), .sync_req(sync_req), .priq_req(priq_req),
    .irq_gerr(irq_gerr), .irq_evq(irq_evq), .irq_sync(irq_sync),
    .unimpl_flag(unimpl_flag)
  );

  AST_STATUS_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !err_rep_valid |=> $stable(status_q)); // R12
  AST_PRIQ_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (priq_req && !evq_req && !sync_req && !err_rep_valid) |=> (!irq_evq && !irq_sync && !irq_gerr)); // R10
endmodule

// File: tb/gerr_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gerr_irq_ctrl_tb_top;
  localparam int NERR = 8;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            err_rep_valid = 1'b0;
  logic [NERR-1:0] err_rep_mask = '0;
  logic            evq_req = 1'b0;
  logic            sync_req = 1'b0;
  logic            priq_req = 1'b0;
  logic            reg_we = 1'b0;
  logic [1:0]      reg_addr = 2'd0;
  logic [DW-1:0]   reg_wdata = '0;
  logic [DW-1:0]   reg_rdata;
  logic            irq_gerr, irq_evq, irq_sync, unimpl_flag;

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [7:0] m_st = 8'h00;
  logic [7:0] m_ack = 8'h00;
  logic [7:0] m_ctl = 8'h00;
  bit m_g = 0, m_e = 0, m_s = 0, m_u = 0;

  always #2.5 clk = ~clk;

  gerr_irq_ctrl #(.NERR(NERR), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .err_rep_valid(err_rep_valid), .err_rep_mask(err_rep_mask),
    .evq_req(evq_req), .sync_req(sync_req), .priq_req(priq_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq_gerr(irq_gerr), .irq_evq(irq_evq), .irq_sync(irq_sync),
    .unimpl_flag(unimpl_flag)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return {24'h0, m_st};
      2'd1: return {24'h0, m_ack};
      2'd2: return {24'h0, m_ctl};
      default: return 32'h0;
    endcase
  endfunction

  // Advance one clock: model follows held inputs, then compare at negedge.
  task automatic step();
    logic [7:0] new_ack, fresh, new_ctl;
    @(posedge clk);
    new_ack = m_ack;
    new_ctl = m_ctl;
    if (reg_we && reg_addr == 2'd1) new_ack = reg_wdata[7:0];
    if (reg_we && reg_addr == 2'd2) new_ctl = {5'b0, reg_wdata[2], 1'b0, reg_wdata[0]};
    fresh = 8'h00;
    if (err_rep_valid)
      for (int i = 0; i < 8; i++)
        if (err_rep_mask[i] && (m_st[i] == new_ack[i])) fresh[i] = 1'b1;
    m_g = (fresh != 0) && m_ctl[0];
    m_e = evq_req && m_ctl[2];
    m_s = sync_req;
    m_u = priq_req;
    m_st  = m_st ^ fresh;
    m_ack = new_ack;
    m_ctl = new_ctl;
    @(negedge clk);
    chk("R4", "irq_gerr", irq_gerr, m_g);
    chk("R6", "irq_evq", irq_evq, m_e);
    chk("R7", "irq_sync", irq_sync, m_s);
    chk("R10", "unimpl_flag", unimpl_flag, m_u);
    chk("R1", "rdata", reg_rdata, model_read(reg_addr));
  endtask

  task automatic idle();
    err_rep_valid = 0; err_rep_mask = '0; evq_req = 0; sync_req = 0;
    priq_req = 0; reg_we = 0; reg_wdata = '0;
  endtask

  task automatic cyc(input bit hv, input logic [7:0] mask, input bit we,
                     input logic [1:0] a, input logic [31:0] wd,
                     input bit ev, input bit sy, input bit pq);
    err_rep_valid = hv; err_rep_mask = mask; reg_we = we; reg_addr = a;
    reg_wdata = wd; evq_req = ev; sync_req = sy; priq_req = pq;
    step();
    idle();
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd(2'd0, v); chk("R1", "reset status", v, 0);
    rd(2'd1, v); chk("R1", "reset ack", v, 0);
    rd(2'd2, v); chk("R1", "reset ctrl", v, 0);
    chk("R5", "reset lines", {irq_gerr, irq_evq, irq_sync, unimpl_flag}, 0);

    // control register keeps only bits 0 and 2
    cyc(0, 8'h00, 1, 2'd2, 32'hFFFF_FFFF, 0, 0, 0);
    rd(2'd2, v); chk("R1", "ctrl sparse", v, 32'h5);
    rd(2'd3, v); chk("R1", "addr3 zero", v, 0);

    // first report on idle pair
    cyc(1, 8'h03, 0, 2'd0, 0, 0, 0, 0);
    chk("R4", "gerr pulse first", irq_gerr, 1);
    rd(2'd0, v); chk("R2", "status after 0x03", v, 32'h03);
    step();
    chk("R5", "gerr one cycle", irq_gerr, 0);

    // overlapping report while errors pending
    cyc(1, 8'h06, 0, 2'd0, 0, 0, 0, 0);
    chk("R4", "gerr pulse with pending", irq_gerr, 1);
    rd(2'd0, v); chk("R2", "only fresh bit flipped", v, 32'h07);

    // report of only active bits
    cyc(1, 8'h05, 0, 2'd0, 0, 0, 0, 0);
    chk("R3", "no pulse stale report", irq_gerr, 0);
    rd(2'd0, v); chk("R3", "status unchanged", v, 32'h07);

    // acknowledge bit0
    cyc(0, 8'h00, 1, 2'd1, 32'h01, 0, 0, 0);
    rd(2'd1, v); chk("R8", "ack stored", v, 32'h01);

    // toggle inactive bit3
    cyc(0, 8'h00, 1, 2'd1, 32'h09, 0, 0, 0);
    chk("R9", "no irq on inactive ack", {irq_gerr, irq_evq, irq_sync, unimpl_flag}, 0);
    rd(2'd1, v); chk("R9", "ack kept verbatim", v, 32'h09);
    step();
    chk("R9", "still quiet", irq_gerr, 0);
    cyc(1, 8'h08, 0, 2'd0, 0, 0, 0, 0);
    rd(2'd0, v); chk("R8", "bit3 active via ack, not flipped", v, 32'h07);

    // status register write ignored
    cyc(0, 8'h00, 1, 2'd0, 32'hFF, 0, 0, 0);
    rd(2'd0, v); chk("R12", "status read-only", v, 32'h07);

    // collision: ack 0x07 clears bits 1,2 (bit3 active->? 0x07^0x07=0) then report 0x06
    err_rep_valid = 1; err_rep_mask = 8'h06; reg_we = 1; reg_addr = 2'd1; reg_wdata = 32'h07;
    step();
    idle();
    chk("R11", "collision pulse", irq_gerr, 1);
    rd(2'd0, v); chk("R11", "collision status", v, 32'h01);
    rd(2'd1, v); chk("R11", "collision ack", v, 32'h07);

    // disable global error enable
    cyc(0, 8'h00, 1, 2'd2, 32'h4, 0, 0, 0);
    cyc(1, 8'h10, 0, 2'd0, 0, 0, 0, 0);
    chk("R4", "gated gerr", irq_gerr, 0);
    rd(2'd0, v); chk("R2", "status flips while gated", v, 32'h11);

    // event queue enabled, then disabled
    cyc(0, 8'h00, 0, 2'd0, 0, 1, 0, 0);
    chk("R6", "evq enabled pulse", irq_evq, 1);
    step();
    chk("R5", "evq one cycle", irq_evq, 0);
    cyc(0, 8'h00, 1, 2'd2, 32'h0, 0, 0, 0);
    cyc(0, 8'h00, 0, 2'd0, 0, 1, 0, 0);
    chk("R6", "evq gated off", irq_evq, 0);

    // sync ungated
    cyc(0, 8'h00, 0, 2'd0, 0, 0, 1, 0);
    chk("R7", "sync pulse", irq_sync, 1);
    cyc(0, 8'h00, 0, 2'd0, 0, 0, 1, 0);
    chk("R7", "sync again", irq_sync, 1);
    step();
    chk("R5", "sync one cycle", irq_sync, 0);

    // unimplemented type
    cyc(0, 8'h00, 1, 2'd2, 32'h5, 0, 0, 0);
    cyc(0, 8'h00, 0, 2'd0, 0, 0, 0, 1);
    chk("R10", "unimpl flag", unimpl_flag, 1);
    chk("R10", "no line on priq", {irq_gerr, irq_evq, irq_sync}, 0);
    step();
    chk("R5", "unimpl one cycle", unimpl_flag, 0);

    // back-to-back fresh reports each pulse
    cyc(1, 8'h20, 0, 2'd0, 0, 0, 0, 0);
    chk("R4", "b2b first", irq_gerr, 1);
    cyc(1, 8'h40, 0, 2'd0, 0, 0, 0, 0);
    chk("R4", "b2b second", irq_gerr, 1);
    repeat (4) step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule